// File: doc/BRIEF.md
# Watchdog and Reset-Source Manager

This block keeps a small controller alive and tells its firmware why it last woke up. A free-running watchdog counts system clocks and, unless software restarts it in time by writing a fixed key value to its service register, forces a chip reset. Software cannot switch the watchdog off. It stops counting only while a chip reset is in progress or while the chip is in suspend.

Two flags in a byte-wide status register record the cause of the last reset. A power-flag is set by a cold start, either power-up or a qualified external reset, and is cleared by software. A wake-flag separates the two warm causes: a resume sets it and a watchdog trip clears it. Warm resets leave the power-flag alone.

Suspend (oscillator stop) is requested through a two-step unlock: the first key byte goes to one address, then the second key byte to the next address. The request output stays high until a resume event arrives. That event produces a warm reset and drops the request.

Top module: `wdog_rstsrc_mgr`

## Requirements
- R1: While `por_i` is high, `chip_rst_o` is high. After power-up the status register at address 0Fh reads 02h, with the power-flag in bit 1 and the wake-flag in bit 0. Every other address reads 00h.
- R2: `chip_rst_o` stays high for RST_HOLD cycles after the last reset trigger. Bus writes made while it is high have no effect.
- R3: A write of 55h to address 0Eh restarts the watchdog count. A write of any other value to 0Eh leaves the count running.
- R4: If the watchdog is not restarted, then WDOG_LIMIT counted cycles after it last restarted, a warm reset is issued. That reset clears the wake-flag and keeps the power-flag.
- R5: `ext_rst_n_i` held low for EXT_MIN_LOW consecutive cycles causes a cold reset, which sets the power-flag to 1 and the wake-flag to 0. Shorter low pulses have no effect.
- R6: A write to 0Fh clears each flag whose data bit is 0. A data bit of 1 never sets a flag.
- R7: The watchdog does not count while `susp_req_o` is high or while `chip_rst_o` is high.
- R8: Writing 55h to 1Eh and then AAh to 1Fh raises `susp_req_o` on the clock edge of the second write. Any other value written to 1Fh, or a non-55h value written to 1Eh, cancels the first step. Writes to other addresses do not cancel it. AAh written to 1Fh without the first step does nothing.
- R9: `susp_req_o` stays high until `resume_i` is seen. A resume while suspended drops `susp_req_o`, raises `chip_rst_o` on the same edge, and sets the wake-flag.
- R10: `resume_i` while not suspended is ignored: no reset occurs and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Synchronous active-high power-on reset (cold) |
| ext_rst_n_i | input | 1 | External reset pin, active low, synchronous to clk |
| resume_i | input | 1 | Resume event from the bus interface |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data for the address of the previous cycle |
| chip_rst_o | output | 1 | Chip reset request, active high |
| susp_req_o | output | 1 | Suspend request, active high |

## Verification
The assertions assume that `por_i` is the only thing that makes the block's state meaningless, and that `resume_i`, `ext_rst_n_i` and the bus inputs are already synchronous to `clk`. The stimulus changes every input on the falling edge only. It keeps each write to a single cycle and keeps servicing the watchdog well inside its period, except where a trip is the purpose of the test. Resume pulses last exactly one cycle, both inside and outside suspend, so that each warm cause can be told apart by the flags alone.

// File: rtl/wrm_pkg.sv
package wrm_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] ADR_WDOG_KICK = 5'h0E;
  localparam logic [REG_AW-1:0] ADR_FLAGS     = 5'h0F;
  localparam logic [REG_AW-1:0] ADR_UNLOCK_A  = 5'h1E;
  localparam logic [REG_AW-1:0] ADR_UNLOCK_B  = 5'h1F;

  localparam logic [REG_DW-1:0] KEY_KICK     = 8'h55;
  localparam logic [REG_DW-1:0] KEY_UNLOCK_A = 8'h55;
  localparam logic [REG_DW-1:0] KEY_UNLOCK_B = 8'hAA;

  localparam int unsigned BIT_POWER = 1;
  localparam int unsigned BIT_WAKE  = 0;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ARMED  = 2'd1,
    SQ_ASLEEP = 2'd2
  } sleep_seq_t;
endpackage

// File: rtl/wrm_pin_qualifier.sv
module wrm_pin_qualifier #(
  parameter int unsigned MIN_LOW = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_LOW);

  logic [CW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
      hit_o   <= 1'b0;
    end else if (pin_n) begin
      low_run <= '0;
      hit_o   <= 1'b0;
    end else begin
      if (low_run != SAT) low_run <= low_run + 1'b1;
      hit_o <= (int'(low_run) >= int'(MIN_LOW) - 1);
    end
  end
endmodule

// File: rtl/wrm_wdog_counter.sv
module wrm_wdog_counter #(
  parameter int unsigned LIMIT = 900000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic kick,
  output logic trip_o
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] ticks;

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks  <= '0;
      trip_o <= 1'b0;
    end else begin
      trip_o <= 1'b0;
      if (hold || kick) begin
        ticks <= '0;
      end else if (ticks == LAST) begin
        ticks  <= '0;
        trip_o <= 1'b1;
      end else begin
        ticks <= ticks + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrm_sleep_seq.sv
module wrm_sleep_seq
  import wrm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic              asleep_o
);
  sleep_seq_t state;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state    <= SQ_IDLE;
      asleep_o <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (wr_en && addr == ADR_UNLOCK_A && wdata == KEY_UNLOCK_A)
            state <= SQ_ARMED;
        end
        SQ_ARMED: begin
          if (wr_en && addr == ADR_UNLOCK_B) begin
            if (wdata == KEY_UNLOCK_B) begin
              state    <= SQ_ASLEEP;
              asleep_o <= 1'b1;
            end else begin
              state <= SQ_IDLE;
            end
          end else if (wr_en && addr == ADR_UNLOCK_A && wdata != KEY_UNLOCK_A) begin
            state <= SQ_IDLE;
          end
        end
        SQ_ASLEEP: state <= SQ_ASLEEP;
        default:   state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdog_rstsrc_mgr.sv
module wdog_rstsrc_mgr
  import wrm_pkg::*;
#(
  parameter int unsigned WDOG_LIMIT  = 900000,
  parameter int unsigned EXT_MIN_LOW = 10,
  parameter int unsigned RST_HOLD    = 4
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              ext_rst_n_i,
  input  logic              resume_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [REG_DW-1:0] bus_wdata_i,
  output logic [REG_DW-1:0] bus_rdata_o,
  output logic              chip_rst_o,
  output logic              susp_req_o
);
  localparam int unsigned HCW = $clog2(RST_HOLD + 1);
  localparam logic [HCW-1:0] HOLD_LOAD = HCW'(RST_HOLD);

  logic           ext_hit;
  logic           wd_ovf;
  logic           cold;
  logic           wake;
  logic           warm;
  logic           wr_ok;
  logic           kick;
  logic           flag_power;
  logic           flag_wake;
  logic [HCW-1:0] hold_left;

  assign cold  = por_i | ext_hit;
  assign wake  = resume_i & susp_req_o;
  assign warm  = wd_ovf | wake;
  assign wr_ok = bus_we_i & ~chip_rst_o;
  assign kick  = wr_ok && bus_addr_i == ADR_WDOG_KICK && bus_wdata_i == KEY_KICK;

  wrm_pin_qualifier #(.MIN_LOW(EXT_MIN_LOW)) u_pin (
    .clk   (clk),
    .rst   (por_i),
    .pin_n (ext_rst_n_i),
    .hit_o (ext_hit)
  );

  wrm_wdog_counter #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk    (clk),
    .rst    (cold),
    .hold   (chip_rst_o | susp_req_o),
    .kick   (kick),
    .trip_o (wd_ovf)
  );

  wrm_sleep_seq u_seq (
    .clk      (clk),
    .rst      (cold),
    .clr      (warm),
    .wr_en    (wr_ok),
    .addr     (bus_addr_i),
    .wdata    (bus_wdata_i),
    .asleep_o (susp_req_o)
  );

  always_ff @(posedge clk) begin
    if (cold) begin
      flag_power <= 1'b1;
      flag_wake  <= 1'b0;
    end else if (wake) begin
      flag_wake <= 1'b1;
    end else if (wd_ovf) begin
      flag_wake <= 1'b0;
    end else if (wr_ok && bus_addr_i == ADR_FLAGS) begin
      flag_power <= flag_power & bus_wdata_i[BIT_POWER];
      flag_wake  <= flag_wake  & bus_wdata_i[BIT_WAKE];
    end
  end

  always_ff @(posedge clk) begin
    if (cold || warm) begin
      hold_left  <= HOLD_LOAD;
      chip_rst_o <= 1'b1;
    end else begin
      hold_left  <= (hold_left != '0) ? hold_left - 1'b1 : '0;
      chip_rst_o <= (hold_left > HCW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      bus_rdata_o <= '0;
    end else if (bus_addr_i == ADR_FLAGS) begin
      bus_rdata_o <= '0;
      bus_rdata_o[BIT_POWER] <= flag_power;
      bus_rdata_o[BIT_WAKE]  <= flag_wake;
    end else begin
      bus_rdata_o <= '0;
    end
  end
endmodule

// File: rtl/wrm_checker.sv
module wrm_checker (
  input logic clk,
  input logic por_i,
  input logic resume_i,
  input logic chip_rst_o,
  input logic susp_req_o,
  input logic wd_ovf,
  input logic ext_hit
);
  // R4: a watchdog trip is followed by a chip reset
  a_r4_trip_resets: assert property (@(posedge clk) disable iff (por_i)
    wd_ovf |=> chip_rst_o);

  // R5: a qualified external reset is followed by a chip reset
  a_r5_ext_resets: assert property (@(posedge clk) disable iff (por_i)
    ext_hit |=> chip_rst_o);

  // R7: no trip while suspended or held in chip reset
  a_r7_frozen_asleep: assert property (@(posedge clk) disable iff (por_i)
    (susp_req_o && $past(susp_req_o)) |-> !wd_ovf);
  a_r7_frozen_in_rst: assert property (@(posedge clk) disable iff (por_i)
    (chip_rst_o && $past(chip_rst_o)) |-> !wd_ovf);

  // R9: suspend persists until a resume, and a resume wakes with a reset
  a_r9_asleep_holds: assert property (@(posedge clk) disable iff (por_i)
    (susp_req_o && !resume_i && !ext_hit && !wd_ovf) |=> susp_req_o);
  a_r9_wake_resets: assert property (@(posedge clk) disable iff (por_i)
    (susp_req_o && resume_i && !ext_hit) |=> (chip_rst_o && !susp_req_o));

  // R10: a resume outside suspend causes nothing
  a_r10_stray_resume: assert property (@(posedge clk) disable iff (por_i)
    (!susp_req_o && resume_i && !chip_rst_o && !wd_ovf && !ext_hit) |=> !chip_rst_o);
endmodule

bind wdog_rstsrc_mgr wrm_checker u_wrm_checker (
  .clk        (clk),
  .por_i      (por_i),
  .resume_i   (resume_i),
  .chip_rst_o (chip_rst_o),
  .susp_req_o (susp_req_o),
  .wd_ovf     (wd_ovf),
  .ext_hit    (ext_hit)
);

// File: tb/tb_wdog_rstsrc_mgr.sv
module tb_wdog_rstsrc_mgr;
  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       ext_rst_n_i = 1'b1;
  logic       resume_i = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [4:0] bus_addr_i = 5'h00;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       chip_rst_o;
  logic       susp_req_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    int         kind;  // 0 read data, 1 chip reset, 2 suspend request
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  wdog_rstsrc_mgr #(.WDOG_LIMIT(64), .EXT_MIN_LOW(10), .RST_HOLD(4)) dut (
    .clk(clk), .por_i(por_i), .ext_rst_n_i(ext_rst_n_i), .resume_i(resume_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .chip_rst_o(chip_rst_o), .susp_req_o(susp_req_o)
  );

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        string what;
        it = sb_q.pop_front();
        if (it.kind == 0)      begin act = bus_rdata_o;          what = "rdata"; end
        else if (it.kind == 1) begin act = {7'b0, chip_rst_o};   what = "chip_rst"; end
        else                   begin act = {7'b0, susp_req_o};   what = "susp_req"; end
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s actual %02h expected %02h", it.req, what, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(int kind, logic [7:0] v, string req);
    item_t it;
    it.kind = kind; it.exp = v; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd_flags(logic [7:0] e, string req);
    @(negedge clk);
    bus_we_i = 1'b0; bus_addr_i = 5'h0F;
    @(negedge clk);
    expect_item(0, e, req);
  endtask

  task automatic pulse_resume();
    @(negedge clk);
    resume_i = 1'b1;
    @(negedge clk);
    resume_i = 1'b0;
  endtask

  initial begin
    // R1: cold power-up
    idle(3);
    expect_item(1, 8'h01, "R1");
    por_i = 1'b0;
    idle(3);
    expect_item(1, 8'h01, "R2");
    idle(1);
    expect_item(1, 8'h00, "R2");
    rd_flags(8'h02, "R1");
    @(negedge clk); bus_addr_i = 5'h03;
    @(negedge clk); expect_item(0, 8'h00, "R1");

    // R6: clear by zero, no set by one
    wr(5'h0F, 8'h00);
    rd_flags(8'h00, "R6");
    wr(5'h0F, 8'hFF);
    rd_flags(8'h00, "R6");

    // R8: second step alone, then full unlock with a foreign write in between
    wr(5'h1F, 8'hAA);
    expect_item(2, 8'h00, "R8");
    wr(5'h1E, 8'h55);
    wr(5'h05, 8'h77);
    wr(5'h1F, 8'hAA);
    expect_item(2, 8'h01, "R8");

    // R7 / R9: long stay in suspend, no watchdog trip
    idle(150);
    expect_item(1, 8'h00, "R7");
    expect_item(2, 8'h01, "R9");

    // R9: resume wakes with a warm reset
    pulse_resume();
    expect_item(1, 8'h01, "R9");
    expect_item(2, 8'h00, "R9");
    wr(5'h0F, 8'h00);  // lands while chip reset is high
    idle(4);
    rd_flags(8'h01, "R2");

    // R10: stray resume
    pulse_resume();
    expect_item(1, 8'h00, "R10");
    expect_item(2, 8'h00, "R10");
    rd_flags(8'h01, "R10");

    // R8: cancellation paths
    wr(5'h1E, 8'h55);
    wr(5'h1F, 8'h12);
    wr(5'h1F, 8'hAA);
    expect_item(2, 8'h00, "R8");
    wr(5'h1E, 8'h55);
    wr(5'h1E, 8'h33);
    wr(5'h1F, 8'hAA);
    expect_item(2, 8'h00, "R8");

    // R3 / R4: wrong key ignored, then trip
    wr(5'h0E, 8'h55);
    idle(20);
    wr(5'h0E, 8'h54);
    idle(38);
    expect_item(1, 8'h00, "R3");
    idle(6);
    expect_item(1, 8'h01, "R4");
    idle(4);
    expect_item(1, 8'h00, "R4");
    rd_flags(8'h00, "R4");

    // R3: regular service keeps the chip running
    for (int i = 0; i < 5; i++) begin
      idle(40);
      wr(5'h0E, 8'h55);
    end
    expect_item(1, 8'h00, "R3");

    // R5: short low pulse ignored, full one causes cold reset
    wr(5'h0E, 8'h55);
    @(negedge clk); ext_rst_n_i = 1'b0;
    repeat (9) @(negedge clk);
    ext_rst_n_i = 1'b1;
    idle(3);
    expect_item(1, 8'h00, "R5");
    wr(5'h0E, 8'h55);
    @(negedge clk); ext_rst_n_i = 1'b0;
    repeat (10) @(negedge clk);
    ext_rst_n_i = 1'b1;
    idle(1);
    expect_item(1, 8'h01, "R5");
    idle(6);
    expect_item(1, 8'h00, "R5");
    rd_flags(8'h02, "R5");

    idle(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule